// File: doc/BRIEF.md
# Subcarrier BPSK Answer Transmitter

This block turns a response payload into the one-bit load-modulation signal a contactless tag returns to its reader. A start request opens a frame. The block then stays silent for a guard interval. Next it sends a stretch of unmodulated subcarrier, which the reader uses as its phase reference. After that it sends the answer as phase changes of the subcarrier: a start delimiter, one 10-bit character per payload byte, two characters that carry a CRC over the payload, and an end delimiter.

The subcarrier is not generated here. The block receives a one-cycle enable, `sc_tick_i`, once per half subcarrier period, and every output change happens on a clock edge where that enable is high. Payload bytes arrive through a ready/valid handshake with a last-byte flag. A one-byte holding register lets the controller supply the next byte while the current character is still being sent. Driving the antenna load is outside this block.

Top module: `bpsk_answer_tx`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no start request, `busy_o`, `mod_o` and `byte_ready_o` are all 0.
- R2: After a start request is accepted, `mod_o` stays 0 for at least 128 subcarrier periods (256 tick intervals), counted from the first tick after the request.
- R3: The guard is followed by exactly 128 subcarrier periods of reference-phase subcarrier. `mod_o` toggles on every tick, and the first half-period is high.
- R4: Each bit lasts 8 subcarrier periods (16 tick intervals) and starts on a bit boundary. A logic 1 is sent in the reference phase, so `mod_o` matches the preamble waveform continued. A logic 0 is sent in the inverted phase.
- R5: The first bit after the preamble begins the start delimiter. The delimiter is 10 bits of logic 0 followed by 2 bits of logic 1, so the first phase flip marks the start bit.
- R6: Each payload byte is sent as a 10-bit character: a start bit of 0, then the 8 data bits with bit 0 first, then a stop bit of 1. Bytes are sent in the order they were accepted.
- R7: The last payload character is followed by two characters that hold the complemented CRC over the payload. The CRC uses polynomial x^16+x^12+x^5+1, processed LSB first, with register preset FFFFh. The low byte is sent first.
- R8: The end delimiter is 10 bits of logic 0 followed by 2 bits of logic 1. At the tick that ends its last bit, `mod_o` returns to 0 and `busy_o` falls.
- R9: `busy_o` rises on the clock edge that accepts `start_i` and stays high until the end of the frame. It falls only on a tick. A start request while busy has no effect on the frame.
- R10: `byte_ready_o` is high only while busy, the holding register is empty and the byte flagged last has not yet been accepted. A byte is taken on a clock edge where `byte_valid_i` and `byte_ready_o` are both high. `byte_last_i` marks the final payload byte.
- R11: If no byte is held when a payload character is due, the block sends logic-1 filler bits, one bit-time each, until a byte arrives. If the byte is held in time, no filler is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sc_tick_i | input | 1 | One-cycle enable per subcarrier half period |
| start_i | input | 1 | Request to begin an answer frame |
| byte_i | input | 8 | Payload byte |
| byte_valid_i | input | 1 | `byte_i` is valid |
| byte_last_i | input | 1 | `byte_i` is the final payload byte |
| byte_ready_o | output | 1 | Block can take a payload byte |
| busy_o | output | 1 | Frame in progress |
| mod_o | output | 1 | Load-modulation output |

## Verification
The bench records `mod_o` once per tick interval and decodes each bit by comparing 16 consecutive half-periods against the reference phase carried forward from the preamble. The test payloads are chosen to separate different faults:
- all-zero bytes and the mixed pattern 0F AA FF have known CRC results, so a wrong CRC preset, polynomial or byte order shows up;
- single-byte and alternating-bit payloads expose a reversed bit order or a misplaced start or stop bit;
- a payload whose second byte arrives late must produce filler bits, which separates correct filler handling from a dropped or repeated character;
- a second start request in the middle of a frame must leave the frame unchanged;
- a reset in the middle of a frame must silence the output at once.

// File: rtl/bpsk_tx_pkg.sv
`timescale 1ns/1ps
package bpsk_tx_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_GUARD, PH_PRE, PH_BITS} phase_e;
  typedef enum logic [2:0] {SEG_SOF, SEG_DATA, SEG_CRCL, SEG_CRCH, SEG_EOF} seg_e;

  localparam int unsigned DELIM_LOW = 10;  // low bits of a delimiter
  localparam int unsigned DELIM_LEN = 12;  // delimiter length in bits
  localparam int unsigned CHAR_LEN  = 10;  // start + 8 data + stop

  // one byte through the reflected CRC register, bit 0 first
  function automatic logic [15:0] crc_step(logic [15:0] crc, logic [7:0] din);
    logic [15:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ din[i]) c = (c >> 1) ^ 16'h8408;
      else               c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/bpsk_tx_timeline.sv
`timescale 1ns/1ps
module bpsk_tx_timeline
  import bpsk_tx_pkg::*;
#(
  parameter int unsigned GUARD_HALF   = 256,
  parameter int unsigned PRE_HALF     = 256,
  parameter int unsigned HALF_PER_BIT = 16
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   start_i,
  input  logic   last_bit_i,
  output logic   busy_o,
  output logic   init_o,
  output logic   bit_adv_o,
  output phase_e phase_o,
  output logic   sc_o
);
  localparam int unsigned CNT_MAX0 = (GUARD_HALF > PRE_HALF) ? GUARD_HALF : PRE_HALF;
  localparam int unsigned CNT_MAX  = (CNT_MAX0 > HALF_PER_BIT) ? CNT_MAX0 : HALF_PER_BIT;
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] GUARD_LIM = CNT_W'(GUARD_HALF);
  localparam logic [CNT_W-1:0] PRE_LIM   = CNT_W'(PRE_HALF - 1);
  localparam logic [CNT_W-1:0] BIT_LIM   = CNT_W'(HALF_PER_BIT - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sc_q;

  assign busy_o    = (phase_q != PH_IDLE);
  assign init_o    = (phase_q == PH_IDLE) && start_i;
  assign bit_adv_o = (phase_q == PH_BITS) && tick_i && (cnt_q == BIT_LIM);
  assign phase_o   = phase_q;
  assign sc_o      = sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sc_q    <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_GUARD;
          cnt_q   <= '0;
        end
        // guard ends one tick late so the partial first interval never shortens it
        PH_GUARD: if (tick_i) begin
          if (cnt_q == GUARD_LIM) begin
            phase_q <= PH_PRE;
            cnt_q   <= '0;
            sc_q    <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_PRE: if (tick_i) begin
          sc_q <= ~sc_q;
          if (cnt_q == PRE_LIM) begin
            phase_q <= PH_BITS;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_BITS: if (tick_i) begin
          sc_q <= ~sc_q;
          if (cnt_q == BIT_LIM) begin
            cnt_q <= '0;
            if (last_bit_i) begin
              phase_q <= PH_IDLE;
              sc_q    <= 1'b0;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bpsk_tx_bytebuf.sv
`timescale 1ns/1ps
module bpsk_tx_bytebuf (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       busy_i,
  input  logic [7:0] byte_i,
  input  logic       valid_i,
  input  logic       last_i,
  input  logic       take_i,
  output logic       ready_o,
  output logic       accept_o,
  output logic       full_o,
  output logic [7:0] data_o,
  output logic       last_o
);
  logic       full_q, last_q, seen_last_q;
  logic [7:0] data_q;

  assign ready_o  = busy_i && !full_q && !seen_last_q;
  assign accept_o = ready_o && valid_i;
  assign full_o   = full_q;
  assign data_o   = data_q;
  assign last_o   = last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q      <= 1'b0;
      last_q      <= 1'b0;
      seen_last_q <= 1'b0;
      data_q      <= '0;
    end else if (init_i) begin
      full_q      <= 1'b0;
      seen_last_q <= 1'b0;
    end else if (accept_o) begin
      full_q      <= 1'b1;
      data_q      <= byte_i;
      last_q      <= last_i;
      seen_last_q <= last_i;
    end else if (take_i) begin
      full_q      <= 1'b0;
    end
  end
endmodule

// File: rtl/bpsk_tx_crc.sv
`timescale 1ns/1ps
module bpsk_tx_crc
  import bpsk_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        accept_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  assign crc_o = ~crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= 16'hFFFF;
    else if (init_i)   crc_q <= 16'hFFFF;
    else if (accept_i) crc_q <= crc_step(crc_q, byte_i);
  end
endmodule

// File: rtl/bpsk_tx_framer.sv
`timescale 1ns/1ps
module bpsk_tx_framer
  import bpsk_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        adv_i,
  input  logic        buf_full_i,
  input  logic [7:0]  buf_byte_i,
  input  logic        buf_last_i,
  input  logic [15:0] crc_i,
  output logic        bit_o,
  output logic        take_o,
  output logic        last_bit_o
);
  localparam logic [3:0] IDX_DLOW = 4'(DELIM_LOW);
  localparam logic [3:0] IDX_DEND = 4'(DELIM_LEN - 1);
  localparam logic [3:0] IDX_CEND = 4'(CHAR_LEN - 1);

  seg_e       seg_q;
  logic [3:0] idx_q;
  logic [7:0] sh_q;
  logic       lastc_q, fill_q;
  logic       load_pt, in_char;

  assign in_char = (seg_q == SEG_DATA) || (seg_q == SEG_CRCL) || (seg_q == SEG_CRCH);
  // points where the next payload character may begin
  assign load_pt = ((seg_q == SEG_SOF) && (idx_q == IDX_DEND)) ||
                   ((seg_q == SEG_DATA) && (fill_q || ((idx_q == IDX_CEND) && !lastc_q)));
  assign take_o     = adv_i && load_pt && buf_full_i;
  assign last_bit_o = (seg_q == SEG_EOF) && (idx_q == IDX_DEND);

  always_comb begin
    if (!in_char)                bit_o = (idx_q >= IDX_DLOW);
    else if (fill_q)             bit_o = 1'b1;
    else if (idx_q == '0)        bit_o = 1'b0;
    else if (idx_q == IDX_CEND)  bit_o = 1'b1;
    else                         bit_o = sh_q[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q   <= SEG_SOF;
      idx_q   <= '0;
      sh_q    <= '0;
      lastc_q <= 1'b0;
      fill_q  <= 1'b0;
    end else if (init_i) begin
      seg_q  <= SEG_SOF;
      idx_q  <= '0;
      fill_q <= 1'b0;
    end else if (adv_i) begin
      if (load_pt) begin
        seg_q <= SEG_DATA;
        idx_q <= '0;
        if (buf_full_i) begin
          sh_q    <= buf_byte_i;
          lastc_q <= buf_last_i;
          fill_q  <= 1'b0;
        end else begin
          fill_q  <= 1'b1;
        end
      end else if (in_char && (idx_q == IDX_CEND)) begin
        idx_q <= '0;
        case (seg_q)
          SEG_DATA: begin seg_q <= SEG_CRCL; sh_q <= crc_i[7:0];  end
          SEG_CRCL: begin seg_q <= SEG_CRCH; sh_q <= crc_i[15:8]; end
          default:  seg_q <= SEG_EOF;
        endcase
      end else begin
        idx_q <= idx_q + 1'b1;
        if (in_char && (idx_q != '0)) sh_q <= sh_q >> 1;
      end
    end
  end
endmodule

// File: rtl/bpsk_answer_tx.sv
`timescale 1ns/1ps
module bpsk_answer_tx
  import bpsk_tx_pkg::*;
#(
  parameter int unsigned SC_PER_BIT  = 8,
  parameter int unsigned GUARD_SC    = 128,
  parameter int unsigned PREAMBLE_SC = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sc_tick_i,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       byte_valid_i,
  input  logic       byte_last_i,
  output logic       byte_ready_o,
  output logic       busy_o,
  output logic       mod_o
);
  localparam int unsigned HALF_PER_BIT = 2 * SC_PER_BIT;
  localparam int unsigned GUARD_HALF   = 2 * GUARD_SC;
  localparam int unsigned PRE_HALF     = 2 * PREAMBLE_SC;

  phase_e      phase;
  logic        sc, init, bit_adv, last_bit, cur_bit, take, accept;
  logic        buf_full, buf_last;
  logic [7:0]  buf_byte;
  logic [15:0] crc;

  bpsk_tx_timeline #(
    .GUARD_HALF  (GUARD_HALF),
    .PRE_HALF    (PRE_HALF),
    .HALF_PER_BIT(HALF_PER_BIT)
  ) u_timeline (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (sc_tick_i),
    .start_i   (start_i),
    .last_bit_i(last_bit),
    .busy_o    (busy_o),
    .init_o    (init),
    .bit_adv_o (bit_adv),
    .phase_o   (phase),
    .sc_o      (sc)
  );

  bpsk_tx_bytebuf u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init),
    .busy_i  (busy_o),
    .byte_i  (byte_i),
    .valid_i (byte_valid_i),
    .last_i  (byte_last_i),
    .take_i  (take),
    .ready_o (byte_ready_o),
    .accept_o(accept),
    .full_o  (buf_full),
    .data_o  (buf_byte),
    .last_o  (buf_last)
  );

  bpsk_tx_crc u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init),
    .accept_i(accept),
    .byte_i  (byte_i),
    .crc_o   (crc)
  );

  bpsk_tx_framer u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init),
    .adv_i     (bit_adv),
    .buf_full_i(buf_full),
    .buf_byte_i(buf_byte),
    .buf_last_i(buf_last),
    .crc_i     (crc),
    .bit_o     (cur_bit),
    .take_o    (take),
    .last_bit_o(last_bit)
  );

  // logic 1 keeps the preamble phase, logic 0 inverts it
  always_comb begin
    case (phase)
      PH_PRE:  mod_o = sc;
      PH_BITS: mod_o = sc ^ ~cur_bit;
      default: mod_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bpsk_answer_tx_chk.sv
`timescale 1ns/1ps
module bpsk_answer_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sc_tick_i,
  input logic start_i,
  input logic byte_valid_i,
  input logic byte_last_i,
  input logic byte_ready_o,
  input logic busy_o,
  input logic mod_o
);
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mod_o); // R8

  AST_MOD_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_tick_i |=> $stable(mod_o)); // R4

  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R9

  AST_BUSY_END_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sc_tick_i) |=> busy_o); // R9

  AST_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> busy_o); // R10

  AST_NO_READY_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_ready_o && byte_last_i) |=> !byte_ready_o); // R10
endmodule

bind bpsk_answer_tx bpsk_answer_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sc_tick_i   (sc_tick_i),
  .start_i     (start_i),
  .byte_valid_i(byte_valid_i),
  .byte_last_i (byte_last_i),
  .byte_ready_o(byte_ready_o),
  .busy_o      (busy_o),
  .mod_o       (mod_o)
);

// File: tb/bpsk_answer_tx_test.sv
`timescale 1ns/1ps
module bpsk_answer_tx_test;
  localparam int HPB  = 16;
  localparam int GH   = 256;
  localparam int PH   = 256;
  localparam int BASE = GH + 1 + PH;
  localparam int CAPN = 4096;

  typedef struct packed {
    logic        gap;    // hold second byte back
    logic        again;  // extra start mid-frame
    logic        chk;    // crc field is a known answer
    logic [2:0]  len;
    logic [31:0] data;   // byte 0 in [7:0]
    logic [15:0] crc;    // transmitted low byte in [7:0]
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 3'd3, 32'h0000_0000, 16'hC6CC},
    '{1'b0, 1'b0, 1'b1, 3'd3, 32'h00FF_AA0F, 16'hD1FC},
    '{1'b0, 1'b0, 1'b0, 3'd1, 32'h0000_005A, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 3'd4, 32'h1234_5678, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 3'd2, 32'h0000_C33C, 16'h0000},
    '{1'b0, 1'b0, 1'b0, 3'd2, 32'h0000_8001, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic byte_valid_i = 1'b0;
  logic byte_last_i = 1'b0;
  logic byte_ready_o, busy_o, mod_o;

  int nchk = 0;
  int nerr = 0;
  logic cap [0:CAPN-1];
  int ncap = 0;
  bit cap_en = 1'b0;

  always #4 clk = ~clk;

  bpsk_answer_tx uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sc_tick_i   (tick),
    .start_i     (start_i),
    .byte_i      (byte_i),
    .byte_valid_i(byte_valid_i),
    .byte_last_i (byte_last_i),
    .byte_ready_o(byte_ready_o),
    .busy_o      (busy_o),
    .mod_o       (mod_o)
  );

  // half-period enable every 4 clocks; record mod_o for the interval it closes
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      if (cap_en && ncap < CAPN) begin
        cap[ncap] = mod_o;
        ncap++;
      end
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  // 0/1 for a clean bit-time, 2 if missing or phase not held for the whole bit
  function automatic int getbit(int k);
    int i0;
    bit b;
    i0 = BASE + HPB * k;
    if (i0 + HPB > ncap) return 2;
    b = (cap[i0] == 1'b1);
    for (int h = 1; h < HPB; h++)
      if ((cap[i0 + h] == ((h % 2) == 0)) != b) return 2;
    return b ? 1 : 0;
  endfunction

  function automatic logic [15:0] ref_crc(vec_t v);
    logic [15:0] c;
    logic [7:0]  ch;
    c = 16'hFFFF;
    for (int i = 0; i < int'(v.len); i++) begin
      ch = v.data[8*i +: 8] ^ c[7:0];
      ch = ch ^ (ch << 4);
      c  = (c >> 8) ^ ({8'h00, ch} << 8) ^ ({8'h00, ch} << 3) ^ ({8'h00, ch} >> 4);
    end
    return ~c;
  endfunction

  task automatic expect_bit(input int exp, input string rq, inout int k);
    int g;
    g = getbit(k);
    chk(g == exp, rq, g, exp);
    k++;
  endtask

  task automatic decode(vec_t v);
    int k, bad, fills, idx;
    logic [15:0] cv;
    logic [7:0] b;
    bad = 0;
    for (int i = 0; i <= GH; i++) if (cap[i] !== 1'b0) bad++;
    chk(bad == 0 && ncap > BASE, "R2", bad, 0);
    bad = 0;
    for (int s = 0; s < PH; s++) if (cap[GH + 1 + s] !== ((s % 2) == 0)) bad++;
    chk(bad == 0, "R3", bad, 0);
    cv = ref_crc(v);
    if (v.chk) chk(cv == v.crc, "R7", cv, v.crc);
    k = 0;
    for (int i = 0; i < 12; i++) expect_bit((i >= 10) ? 1 : 0, "R5", k);
    fills = 0;
    for (int c = 0; c < int'(v.len) + 2; c++) begin
      if (c < int'(v.len)) b = v.data[8*c +: 8];
      else if (c == int'(v.len)) b = cv[7:0];
      else b = cv[15:8];
      while (getbit(k) == 1 && fills < 200) begin fills++; k++; end
      expect_bit(0, (c < int'(v.len)) ? "R6" : "R7", k);
      for (int i = 0; i < 8; i++) expect_bit(int'(b[i]), (c < int'(v.len)) ? "R6" : "R7", k);
      expect_bit(1, (c < int'(v.len)) ? "R6" : "R7", k);
    end
    for (int i = 0; i < 12; i++) expect_bit((i >= 10) ? 1 : 0, "R8", k);
    bad = 0;
    for (int j = 0; j < k; j++) if (getbit(j) == 2) bad++;
    chk(bad == 0, "R4", bad, 0);
    idx = BASE + HPB * k;
    chk(idx + 1 < ncap && cap[idx] == 1'b0 && cap[idx + 1] == 1'b0, "R8", int'(cap[idx]), 0);
    if (v.gap) chk(fills > 0, "R11", fills, 1);
    else       chk(fills == 0, "R11", fills, 0);
  endtask

  task automatic launch();
    do @(posedge clk); while (!tick);
    #1;
    start_i = 1'b1;
    ncap = 0;
    cap_en = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9", int'(busy_o), 1);
  endtask

  task automatic run_vec(vec_t v);
    launch();
    fork
      begin
        for (int i = 0; i < int'(v.len); i++) begin
          if (v.gap && i == 1) repeat (6000) @(posedge clk);
          @(posedge clk); #1;
          byte_valid_i = 1'b1;
          byte_i       = v.data[8*i +: 8];
          byte_last_i  = (i == int'(v.len) - 1);
          while (!byte_ready_o) begin @(posedge clk); #1; end
          @(posedge clk); #1;
          byte_valid_i = 1'b0;
          if (i == int'(v.len) - 1) chk(byte_ready_o == 1'b0, "R10", int'(byte_ready_o), 0);
        end
      end
      begin
        if (v.again) begin
          repeat (1500) @(posedge clk); #1;
          start_i = 1'b1;
          @(posedge clk); #1;
          start_i = 1'b0;
          chk(busy_o == 1'b1, "R9", int'(busy_o), 1);
        end
      end
    join
    while (busy_o) begin @(posedge clk); #1; end
    repeat (24) @(posedge clk);
    #1;
    cap_en = 1'b0;
    chk(byte_ready_o == 1'b0 && mod_o == 1'b0, "R10", int'(byte_ready_o), 0);
    decode(v);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk(busy_o == 1'b0 && mod_o == 1'b0 && byte_ready_o == 1'b0, "R1", int'(busy_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(posedge clk); #1;
    chk(busy_o == 1'b0 && mod_o == 1'b0 && byte_ready_o == 1'b0, "R1", int'(busy_o), 0);

    for (int n = 0; n < NV; n++) run_vec(VEC[n]);

    // reset in the middle of the preamble
    launch();
    repeat (1500) @(posedge clk); #1;
    rst_ni = 1'b0;
    #1;
    chk(busy_o == 1'b0 && mod_o == 1'b0 && byte_ready_o == 1'b0, "R1", int'(busy_o), 0);
    cap_en = 1'b0;
    @(posedge clk); #1;
    rst_ni = 1'b1;
    repeat (5) @(posedge clk); #1;
    chk(busy_o == 1'b0 && mod_o == 1'b0, "R1", int'(mod_o), 0);
    run_vec(VEC[2]);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule